// File: doc/BRIEF.md
# Ring Slot First-Hit and Expiry Tracker

The block keeps two status flags and an age counter for every slot of a ring of crossing buffers. One slot is used per beam crossing, and the ring wraps after a fixed number of crossings. The first hit written into a slot during a crossing pulses that slot's buffer reset, so leftovers from the previous pass around the ring are thrown away. It also raises both flags and starts the slot's age counter, which counts crossing ticks. The short flag drops after a small number of ticks. A later write to the slot after that point is again treated as a first hit. The long flag drops after roughly one full ring pass, and from then on reads of the slot are refused as stale.

The buffer reset needs a few clock cycles to settle in the slot storage. For that many cycles after a reset pulse, the slot is marked busy. Writes to a busy slot are refused and the writer retries. A write that triggers the reset is also refused, so the hit is presented again once the reset has completed. A separate crossing-change compare input forces the reset even when the short flag is still set. Synchronizers between clock domains sit outside this block.

Top module: `slot_age_tracker`

## Requirements
- R1: After reset, every slot has both flags clear and no busy time. A read of any slot returns rd_valid low, and no fifo_rst bit is high.
- R2: fifo_rst is one-hot at bit wr_slot in a cycle where wr_en is high, the slot is not busy, and either its short flag is clear or bco_cmp is high. All other bits are zero. In every other cycle fifo_rst is zero.
- R3: A write to a slot that is not busy, whose short flag is set, with bco_cmp low, raises wr_ok and no reset.
- R4: The write that causes a reset sees wr_ok low. For the next RST_CYCLES cycles that slot is busy: writes to it see wr_ok low and fifo_rst low.
- R5: The short flag is set by the reset write. It clears on the SHORT_TICKS-th bco_tick that follows, after which the next write to the slot resets it again.
- R6: rd_valid equals rd_en and the long flag of slot rd_slot. The long flag is set by the reset write and clears on the LONG_TICKS-th bco_tick that follows.
- R7: If a reset write and a bco_tick fall in the same cycle, the age restarts at zero and that tick is not counted.
- R8: A write, reset or busy period on one slot leaves the flags, age and busy state of every other slot unchanged.
- R9: wr_ok and fifo_rst are low whenever wr_en is low. rd_valid is low whenever rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bco_tick | input | 1 | One-cycle pulse per crossing advance |
| wr_en | input | 1 | Hit write request |
| wr_slot | input | SLOT_W | Slot addressed by the write |
| bco_cmp | input | 1 | Crossing-change compare; forces a reset on a write |
| rd_en | input | 1 | Read request |
| rd_slot | input | SLOT_W | Slot addressed by the read |
| fifo_rst | output | NUM_SLOTS | Per-slot buffer reset pulse |
| wr_ok | output | 1 | Write accepted this cycle |
| rd_valid | output | 1 | Slot contents are current and may be read |

## Verification
The directed part of the bench writes a slot for the first time, then again while its short flag is set, and then re-writes it after the short threshold. This separates the reset path from the accept path. A reset paired with a tick in the same cycle shows whether the age restarts or counts on by one. Repeated writes during the busy window show whether the hold-off lasts exactly RST_CYCLES cycles. A long pseudo-random sweep over a small ring mixes ticks, compares, reads and writes on all slots, and checks against an arithmetic reference model. It finds faults that leak between slots and off-by-one errors in either expiry threshold.

// File: rtl/sat_pkg.sv
package sat_pkg;
   // width able to hold values 0..n, never below one bit
   function automatic int cnt_width(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

   typedef struct packed {
      logic fresh;   // short flag: first hit of this crossing already taken
      logic live;    // long flag: contents belong to current ring pass
   } slot_flags_t;
endpackage

// File: rtl/sat_slot_cell.sv
module sat_slot_cell
   import sat_pkg::*;
#(
   parameter int SHORT_TICKS = 1,
   parameter int LONG_TICKS  = 64,
   localparam int AGE_W      = cnt_width(LONG_TICKS)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick,
   input  logic        load,
   output slot_flags_t flags_o
);
   logic [AGE_W-1:0] age_q;
   logic [AGE_W-1:0] age_nx;
   slot_flags_t      flags_q;

   assign age_nx  = age_q + 1'b1;
   assign flags_o = flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age_q         <= '0;
         flags_q.fresh <= 1'b0;
         flags_q.live  <= 1'b0;
      end else if (load) begin
         age_q         <= '0;
         flags_q.fresh <= 1'b1;
         flags_q.live  <= 1'b1;
      end else if (tick && flags_q.live) begin
         age_q <= age_nx;
         if (age_nx >= AGE_W'(SHORT_TICKS)) flags_q.fresh <= 1'b0;
         if (age_nx >= AGE_W'(LONG_TICKS))  flags_q.live  <= 1'b0;
      end
   end
endmodule

// File: rtl/sat_rst_hold.sv
module sat_rst_hold
   import sat_pkg::*;
#(
   parameter int RST_CYCLES = 4,
   localparam int HOLD_W    = cnt_width(RST_CYCLES)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic busy_o
);
   logic [HOLD_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= HOLD_W'(RST_CYCLES);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/slot_age_tracker.sv
module slot_age_tracker
   import sat_pkg::*;
#(
   parameter int NUM_SLOTS   = 64,
   parameter int SHORT_TICKS = 1,
   parameter int LONG_TICKS  = 64,
   parameter int RST_CYCLES  = 4,
   localparam int SLOT_W     = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bco_tick,
   input  logic                 wr_en,
   input  logic [SLOT_W-1:0]    wr_slot,
   input  logic                 bco_cmp,
   input  logic                 rd_en,
   input  logic [SLOT_W-1:0]    rd_slot,
   output logic [NUM_SLOTS-1:0] fifo_rst,
   output logic                 wr_ok,
   output logic                 rd_valid
);
   // elaboration-time parameter checks
   if (NUM_SLOTS < 2 || (1 << SLOT_W) != NUM_SLOTS) begin : g_bad_slots
      $error("NUM_SLOTS must be a power of two, at least 2");
   end
   if (SHORT_TICKS < 1 || SHORT_TICKS > LONG_TICKS) begin : g_bad_short
      $error("SHORT_TICKS must lie in 1..LONG_TICKS");
   end
   if (RST_CYCLES < 0) begin : g_bad_hold
      $error("RST_CYCLES must not be negative");
   end

   slot_flags_t [NUM_SLOTS-1:0] flags_v;
   logic        [NUM_SLOTS-1:0] busy_v;
   logic                        sel_busy;
   logic                        sel_first;
   logic                        do_rst;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      sat_slot_cell #(
         .SHORT_TICKS (SHORT_TICKS),
         .LONG_TICKS  (LONG_TICKS)
      ) cell_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (bco_tick),
         .load    (fifo_rst[s]),
         .flags_o (flags_v[s])
      );
   end

   // variant: with or without a reset hold-off timer
   if (RST_CYCLES > 0) begin : g_hold
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_timer
         sat_rst_hold #(.RST_CYCLES(RST_CYCLES)) hold_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (fifo_rst[s]),
            .busy_o (busy_v[s])
         );
      end
   end else begin : g_nohold
      assign busy_v = '0;
   end

   assign sel_busy  = busy_v[wr_slot];
   assign sel_first = !flags_v[wr_slot].fresh;
   assign do_rst    = wr_en && !sel_busy && (sel_first || bco_cmp);

   always_comb begin
      fifo_rst = '0;
      if (do_rst) fifo_rst[wr_slot] = 1'b1;
   end

   assign wr_ok    = wr_en && !sel_busy && !do_rst;
   assign rd_valid = rd_en && flags_v[rd_slot].live;
endmodule

// File: rtl/sat_checker.sv
module sat_checker #(
   parameter int NUM_SLOTS  = 64,
   parameter int RST_CYCLES = 4,
   localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic [SLOT_W-1:0]    wr_slot,
   input logic                 rd_en,
   input logic [SLOT_W-1:0]    rd_slot,
   input logic [NUM_SLOTS-1:0] fifo_rst,
   input logic                 wr_ok,
   input logic                 rd_valid
);
   assert_rst_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fifo_rst));

   assert_rst_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|fifo_rst) |-> (wr_en && fifo_rst[wr_slot]));

   assert_rst_refuses_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|fifo_rst) |-> !wr_ok);

   if (RST_CYCLES > 0) begin : g_hold_chk
      assert_busy_after_rst_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (|fifo_rst) |=> !(wr_en && (wr_slot == $past(wr_slot)) && (wr_ok || (|fifo_rst))));
   end

   assert_live_after_rst_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|fifo_rst) |=> ((rd_en && (rd_slot == $past(wr_slot))) -> rd_valid));

   assert_idle_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> (!wr_ok && fifo_rst == '0));

   assert_idle_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> !rd_valid);
endmodule

bind slot_age_tracker sat_checker #(
   .NUM_SLOTS  (NUM_SLOTS),
   .RST_CYCLES (RST_CYCLES)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_slot  (wr_slot),
   .rd_en    (rd_en),
   .rd_slot  (rd_slot),
   .fifo_rst (fifo_rst),
   .wr_ok    (wr_ok),
   .rd_valid (rd_valid)
);

// File: tb/slot_age_tracker_tb_top.sv
module slot_age_tracker_tb_top;
   localparam int NS  = 8;
   localparam int SH  = 2;
   localparam int LG  = 5;
   localparam int RC  = 2;
   localparam int SW  = $clog2(NS);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bco_tick = 1'b0;
   logic          wr_en = 1'b0;
   logic [SW-1:0] wr_slot = '0;
   logic          bco_cmp = 1'b0;
   logic          rd_en = 1'b0;
   logic [SW-1:0] rd_slot = '0;
   logic [NS-1:0] fifo_rst;
   logic          wr_ok;
   logic          rd_valid;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // reference model state
   bit m_s [NS];
   bit m_l [NS];
   int m_age [NS];
   int m_b [NS];

   always #2.5 clk = ~clk;

   slot_age_tracker #(
      .NUM_SLOTS(NS), .SHORT_TICKS(SH), .LONG_TICKS(LG), .RST_CYCLES(RC)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .bco_tick(bco_tick), .wr_en(wr_en),
      .wr_slot(wr_slot), .bco_cmp(bco_cmp), .rd_en(rd_en), .rd_slot(rd_slot),
      .fifo_rst(fifo_rst), .wr_ok(wr_ok), .rd_valid(rd_valid)
   );

   task automatic chk(input string tag, input logic [NS-1:0] act, input logic [NS-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   // one cycle: drive at negedge, compare before the edge, advance the model
   task automatic step(input bit we, input int ws, input bit cmp, input bit tk,
                       input bit re, input int rs, input string tag);
      bit busy, e_rst, e_ok, e_rv;
      logic [NS-1:0] e_vec;
      @(negedge clk);
      wr_en = we; wr_slot = SW'(ws); bco_cmp = cmp; bco_tick = tk;
      rd_en = re; rd_slot = SW'(rs);
      #1;
      busy  = (m_b[ws] != 0);
      e_rst = we && !busy && (!m_s[ws] || cmp);
      e_ok  = we && !busy && !e_rst;
      e_rv  = re && m_l[rs];
      e_vec = e_rst ? (NS'(1) << ws) : '0;
      chk({tag, " R2 fifo_rst"}, fifo_rst, e_vec);
      chk({tag, " R4 wr_ok"}, NS'(wr_ok), NS'(e_ok));
      chk({tag, " R6 rd_valid"}, NS'(rd_valid), NS'(e_rv));
      for (int i = 0; i < NS; i++) begin
         if (m_b[i] > 0) m_b[i]--;
         if (e_rst && i == ws) begin
            m_s[i] = 1; m_l[i] = 1; m_age[i] = 0; m_b[i] = RC;
         end else if (tk && m_l[i]) begin
            m_age[i]++;
            if (m_age[i] >= SH) m_s[i] = 0;
            if (m_age[i] >= LG) m_l[i] = 0;
         end
      end
   endtask

   initial begin
      for (int i = 0; i < NS; i++) begin m_s[i] = 0; m_l[i] = 0; m_age[i] = 0; m_b[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: nothing valid after reset
      for (int i = 0; i < NS; i++) step(0, 0, 0, 0, 1, i, "R1 reset read");
      // first hit resets, then busy window, then accepted (R3, R4)
      step(1, 3, 0, 0, 1, 3, "R4 first hit");
      for (int i = 0; i < RC; i++) step(1, 3, 0, 0, 1, 3, "R4 busy");
      step(1, 3, 0, 0, 1, 3, "R3 accept");
      // compare forces a reset while short flag set (R2)
      step(1, 3, 1, 0, 0, 0, "R2 compare");
      for (int i = 0; i < RC + 1; i++) step(1, 3, 0, 0, 0, 0, "R2 after compare");
      // R5: short flag expiry, then re-reset
      for (int i = 0; i < SH; i++) step(1, 3, 0, 1, 1, 3, "R5 ticks");
      step(1, 3, 0, 0, 1, 3, "R5 rewrite");
      // R6: long expiry
      for (int i = 0; i < LG + 1; i++) step(0, 0, 0, 1, 1, 3, "R6 expiry");
      // R7: reset and tick together
      step(1, 5, 0, 1, 1, 5, "R7 reset with tick");
      for (int i = 0; i < LG + 1; i++) step(1, 5, 0, 1, 1, 5, "R7 age");
      // R8 and R9: idle and cross-slot checks via sweep
      for (int n = 0; n < 6000; n++) begin
         int r = $urandom;
         step(r[0], r[7:5], r[10:8] == 3'd0, r[12:11] == 2'd0, r[13], r[16:14],
              (r[0] ? "R8 sweep" : "R9 sweep"));
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #150000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule